// File: doc/BRIEF.md
# I2C Target Byte-Memory Emulator

This block makes an I2C target look like a small byte-addressed memory. An upstream engine handles bit timing and address shifting. It passes each bus event to this block as a one-cycle strobe: a start (with the 7-bit address and the direction bit), a stop, a received byte, or a request for a byte to transmit. The block holds the storage array and an address pointer that advances after every access. After a write-direction start, the first received byte sets the pointer instead of being stored.

A single programmable address window can be loaded at run time. Every data write that lands inside the window raises a one-cycle notification carrying the written address and byte, so nearby logic can follow updates to a region of interest. A window that would reach past the end of the array is refused, and the window already in place is kept.

Top module: `i2c_eeprom_emu`

## Requirements
- R1: After reset the pointer is 0, every storage byte is 0x00, no window is armed, and all outputs are 0.
- R2: A start selects the block only when its 7-bit address equals OWN_ADDR (default 0x01). While the block is not selected, received bytes are NAKed and ignored, and transmit requests return 0x00. A stop deselects the block.
- R3: A selected write-direction start (`start_rd_i`=0) arms pointer loading. The next accepted byte loads the pointer with its value modulo DEPTH, is not stored, and disarms loading.
- R4: A read-direction start or a stop disarms pointer loading. A later received byte is then treated as data.
- R5: A transmit request while enabled and selected returns the byte at the pointer on `tx_byte_o` in the next cycle, with `tx_vld_o` high, and advances the pointer modulo DEPTH.
- R6: A data write stores the byte at the pointer and advances the pointer modulo DEPTH, so writing at address DEPTH-1 wraps the pointer to 0.
- R7: Every received byte yields `rx_ack_vld_o` in the next cycle. `rx_ack_o` is 1 (ACK) when the block is enabled and selected, and this includes the pointer byte; otherwise it is 0 (NAK).
- R8: With `en_i` low, transmit requests return 0x00, received bytes are NAKed, and neither storage nor the pointer changes.
- R9: A window request with start S and size Z is accepted when Z is non-zero and S+Z ≤ DEPTH. Acceptance pulses `cfg_ok_o` in the next cycle and sets the window to [S, S+Z-1]. Otherwise `cfg_err_o` pulses and the old window stays in place.
- R10: A data write to an address inside the armed window pulses `hit_o` in the next cycle, with `hit_addr_o` and `hit_data_o` giving the address and the byte. Pointer-load bytes and writes outside the window give no pulse.
- R11: When a data write and a window request arrive in the same cycle, the write is judged against the window that was in effect before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Emulator enable |
| start_i | input | 1 | Start/repeated-start strobe |
| start_addr_i | input | 7 | Target address seen with the start |
| start_rd_i | input | 1 | Direction of the start, 1 = read |
| stop_i | input | 1 | Stop strobe |
| rx_vld_i | input | 1 | Received-byte strobe |
| rx_byte_i | input | 8 | Received byte |
| rx_ack_vld_o | output | 1 | Acknowledge decision valid |
| rx_ack_o | output | 1 | 1 = ACK, 0 = NAK |
| tx_req_i | input | 1 | Transmit-byte request strobe |
| tx_vld_o | output | 1 | Transmit byte valid |
| tx_byte_o | output | 8 | Byte to transmit |
| cfg_vld_i | input | 1 | Window request strobe |
| cfg_start_i | input | AW | Window start address |
| cfg_size_i | input | AW+1 | Window size in bytes |
| cfg_ok_o | output | 1 | Window request accepted |
| cfg_err_o | output | 1 | Window request refused |
| hit_o | output | 1 | Watched-write notification |
| hit_addr_o | output | AW | Address of the watched write |
| hit_data_o | output | 8 | Byte of the watched write |

## Verification
A data write and a window update can fall in the same cycle. The write then has to be judged against the window that was in effect before the update, not the new one. The bench provokes this with a directed case: it writes to an address that lies only inside the incoming window while that window is being loaded, expects no notification, and then expects one when the same address is rewritten. Random traffic also mixes simultaneous write/window pairs into the stream, and the bench model settles each one with the old window before it applies the new one.

// File: rtl/ee_pkg.sv
// Shared types for the I2C byte-memory emulator.
package ee_pkg;
    typedef logic [7:0] byte_t;

    // Access decoded from a bus event for the current cycle
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } ee_op_e;
endpackage

// File: rtl/ee_ptr_ctrl.sv
// Pointer and session control. Tracks selection and the pointer-load flag,
// decodes each bus strobe into an access, owns the address pointer and the
// acknowledge decision. Assumes strobes are mutually exclusive and that
// DEPTH is a power of two no larger than 256.
module ee_ptr_ctrl
    import ee_pkg::*;
#(
    parameter int          DEPTH    = 256,
    parameter logic [6:0]  OWN_ADDR = 7'h01,
    localparam int         AW       = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          start,
    input  logic [6:0]    start_addr,
    input  logic          start_rd,
    input  logic          stop,
    input  logic          rx_vld,
    input  byte_t         rx_byte,
    input  logic          tx_req,
    output ee_op_e        op,
    output logic [AW-1:0] ptr,
    output logic          ack_vld,
    output logic          ack
);
    logic sel_q;
    logic pnext_q;
    logic access;

    assign access = en && sel_q;

    // Decode the strobe into the access performed this cycle
    always_comb begin
        op = OP_NONE;
        if (rx_vld && access)
            op = pnext_q ? OP_LOAD : OP_WRITE;
        else if (tx_req && access)
            op = OP_READ;
    end

    // Selection and pointer-load flag follow start and stop events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= 1'b0;
            pnext_q <= 1'b0;
        end else if (start) begin
            sel_q   <= (start_addr == OWN_ADDR);
            pnext_q <= (start_addr == OWN_ADDR) && !start_rd;
        end else if (stop) begin
            sel_q   <= 1'b0;
            pnext_q <= 1'b0;
        end else if (op == OP_LOAD) begin
            pnext_q <= 1'b0;
        end
    end

    // Pointer: loaded from the first byte, advanced by each data access
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (op == OP_LOAD)
            ptr <= rx_byte[AW-1:0];
        else if (op == OP_WRITE || op == OP_READ)
            ptr <= ptr + 1'b1;
    end

    // Acknowledge decision for every received byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_vld <= 1'b0;
            ack     <= 1'b0;
        end else begin
            ack_vld <= rx_vld;
            ack     <= rx_vld && access;
        end
    end

    // R3
    ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LOAD) |=> (ptr == $past(rx_byte[AW-1:0])));
    // R4
    stop_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !start) |=> !pnext_q && !sel_q);
    // R6
    ptr_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WRITE || op == OP_READ) |=> (ptr == AW'($past(ptr) + 1)));
    // R7
    ack_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_vld |=> ack_vld);
endmodule

// File: rtl/ee_mem.sv
// Storage array with one write port and a registered read port. The read
// result is zero when a request arrives without a permitted access.
module ee_mem
    import ee_pkg::*;
#(
    parameter  int DEPTH = 256,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  byte_t         wdata,
    input  logic          rd_req,
    input  logic          rd_en,
    output byte_t         rdata
);
    byte_t mem_q [DEPTH];

    // Array write and reset-to-zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem_q[i] <= '0;
        end else if (we) begin
            mem_q[addr] <= wdata;
        end
    end

    // Registered read, zero when the access is not permitted
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_req)
            rdata <= rd_en ? mem_q[addr] : '0;
    end
endmodule

// File: rtl/ee_watch.sv
// Single address window. Checks each window request against the array
// size, and flags data writes that fall within the armed window using the
// window held before the current cycle.
module ee_watch
    import ee_pkg::*;
#(
    parameter  int DEPTH = 256,
    localparam int AW    = $clog2(DEPTH),
    localparam int SW    = AW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_vld,
    input  logic [AW-1:0] cfg_start,
    input  logic [AW:0]   cfg_size,
    output logic          cfg_ok,
    output logic          cfg_err,
    input  logic          wr,
    input  logic [AW-1:0] wr_addr,
    input  byte_t         wr_data,
    output logic          hit,
    output logic [AW-1:0] hit_addr,
    output byte_t         hit_data
);
    logic          win_v;
    logic [AW-1:0] lo_q, hi_q;
    logic [SW-1:0] span_end;
    logic          fits;

    assign span_end = SW'(cfg_start) + SW'(cfg_size);
    assign fits     = (cfg_size != '0) && (span_end <= SW'(DEPTH));

    // Window registers and request response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_v   <= 1'b0;
            lo_q    <= '0;
            hi_q    <= '0;
            cfg_ok  <= 1'b0;
            cfg_err <= 1'b0;
        end else begin
            cfg_ok  <= cfg_vld && fits;
            cfg_err <= cfg_vld && !fits;
            if (cfg_vld && fits) begin
                win_v <= 1'b1;
                lo_q  <= cfg_start;
                hi_q  <= AW'(span_end - 1'b1);
            end
        end
    end

    // Notification for writes inside the window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit      <= 1'b0;
            hit_addr <= '0;
            hit_data <= '0;
        end else begin
            hit <= wr && win_v && (wr_addr >= lo_q) && (wr_addr <= hi_q);
            if (wr) begin
                hit_addr <= wr_addr;
                hit_data <= wr_data;
            end
        end
    end

    // R9
    cfg_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ok || cfg_err) |-> $past(cfg_vld) && $onehot0({cfg_ok, cfg_err}));
    // R10
    hit_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(wr) && $past(win_v));
endmodule

// File: rtl/i2c_eeprom_emu.sv
// Top of the I2C byte-memory emulator. Connects the pointer control, the
// storage array and the address window. Assumes the upstream engine gives
// at most one bus strobe (start, stop, rx, tx) per cycle.
module i2c_eeprom_emu
    import ee_pkg::*;
#(
    parameter  int         DEPTH    = 256,
    parameter  logic [6:0] OWN_ADDR = 7'h01,
    localparam int         AW       = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          start_i,
    input  logic [6:0]    start_addr_i,
    input  logic          start_rd_i,
    input  logic          stop_i,
    input  logic          rx_vld_i,
    input  logic [7:0]    rx_byte_i,
    output logic          rx_ack_vld_o,
    output logic          rx_ack_o,
    input  logic          tx_req_i,
    output logic          tx_vld_o,
    output logic [7:0]    tx_byte_o,
    input  logic          cfg_vld_i,
    input  logic [AW-1:0] cfg_start_i,
    input  logic [AW:0]   cfg_size_i,
    output logic          cfg_ok_o,
    output logic          cfg_err_o,
    output logic          hit_o,
    output logic [AW-1:0] hit_addr_o,
    output logic [7:0]    hit_data_o
);
    ee_op_e        op;
    logic [AW-1:0] ptr;
    logic          data_wr;

    assign data_wr = (op == OP_WRITE);

    ee_ptr_ctrl #(.DEPTH(DEPTH), .OWN_ADDR(OWN_ADDR)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .en(en_i),
        .start(start_i), .start_addr(start_addr_i), .start_rd(start_rd_i),
        .stop(stop_i), .rx_vld(rx_vld_i), .rx_byte(rx_byte_i),
        .tx_req(tx_req_i), .op(op), .ptr(ptr),
        .ack_vld(rx_ack_vld_o), .ack(rx_ack_o)
    );

    ee_mem #(.DEPTH(DEPTH)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(data_wr), .addr(ptr),
        .wdata(rx_byte_i), .rd_req(tx_req_i), .rd_en(op == OP_READ),
        .rdata(tx_byte_o)
    );

    ee_watch #(.DEPTH(DEPTH)) u_watch (
        .clk(clk), .rst_n(rst_n), .cfg_vld(cfg_vld_i),
        .cfg_start(cfg_start_i), .cfg_size(cfg_size_i),
        .cfg_ok(cfg_ok_o), .cfg_err(cfg_err_o),
        .wr(data_wr), .wr_addr(ptr), .wr_data(rx_byte_i),
        .hit(hit_o), .hit_addr(hit_addr_o), .hit_data(hit_data_o)
    );

    // Transmit-valid strobe, one cycle after each request
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_vld_o <= 1'b0;
        else
            tx_vld_o <= tx_req_i;
    end

    // R8
    off_tx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req_i && !en_i) |=> (tx_vld_o && tx_byte_o == 8'h00));
    // R8
    off_rx_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_vld_i && !en_i) |=> !rx_ack_o);
    // R10
    hit_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (hit_addr_o == $past(ptr)) && (hit_data_o == $past(rx_byte_i)));
endmodule

// File: tb/tb_i2c_eeprom_emu.sv
module tb_i2c_eeprom_emu;
    localparam int DEPTH = 256;
    localparam int AW    = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n, en_i, start_i, start_rd_i, stop_i, rx_vld_i, tx_req_i, cfg_vld_i;
    logic [6:0]    start_addr_i;
    logic [7:0]    rx_byte_i;
    logic [AW-1:0] cfg_start_i;
    logic [AW:0]   cfg_size_i;
    logic          rx_ack_vld_o, rx_ack_o, tx_vld_o, cfg_ok_o, cfg_err_o, hit_o;
    logic [7:0]    tx_byte_o, hit_data_o;
    logic [AW-1:0] hit_addr_o;

    i2c_eeprom_emu dut (.*);

    logic [7:0] m_mem [DEPTH];
    int  m_ptr, m_lo, m_hi;
    bit  m_sel, m_pn, m_wv;
    int  checks = 0, fails = 0;
    bit  done = 0;

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic string pick(string t, string d);
        return (t == "") ? d : t;
    endfunction

    function automatic bit in_win(int a);
        return m_wv && a >= m_lo && a <= m_hi;
    endfunction

    function automatic bit win_fits(int s, int z);
        return z != 0 && s + z <= DEPTH;
    endfunction

    // One bus cycle: drive at negedge, update model, check at next negedge
    task automatic step(bit s, bit [6:0] a, bit rd, bit sp, bit rv, bit [7:0] rb,
                        bit tr, bit cv, bit [7:0] cs, bit [8:0] cz, string t);
        bit acc, e_ack, e_hit, fit;
        int e_tx, e_ha;
        start_i = s; start_addr_i = a; start_rd_i = rd; stop_i = sp;
        rx_vld_i = rv; rx_byte_i = rb; tx_req_i = tr;
        cfg_vld_i = cv; cfg_start_i = cs; cfg_size_i = cz;
        acc = en_i && m_sel;
        e_ack = rv && acc; e_hit = 0; e_tx = 0; e_ha = 0;
        if (rv && acc) begin
            if (m_pn) begin
                m_ptr = rb % DEPTH; m_pn = 0;
            end else begin
                e_hit = in_win(m_ptr); e_ha = m_ptr;
                m_mem[m_ptr] = rb; m_ptr = (m_ptr + 1) % DEPTH;
            end
        end else if (tr && acc) begin
            e_tx = m_mem[m_ptr]; m_ptr = (m_ptr + 1) % DEPTH;
        end
        if (s) begin
            m_sel = (a == 7'h01); m_pn = (a == 7'h01) && !rd;
        end else if (sp) begin
            m_sel = 0; m_pn = 0;
        end
        fit = win_fits(cs, cz);
        if (cv && fit) begin
            m_wv = 1; m_lo = cs; m_hi = cs + cz - 1;
        end
        @(posedge clk);
        @(negedge clk);
        chk(rx_ack_vld_o == rv, pick(t, "R7 ack valid"), rx_ack_vld_o, rv);
        if (rv) chk(rx_ack_o == e_ack, pick(t, "R7 ack"), rx_ack_o, e_ack);
        chk(tx_vld_o == tr, pick(t, "R5 tx valid"), tx_vld_o, tr);
        if (tr) chk(tx_byte_o == e_tx, pick(t, en_i ? "R5 tx byte" : "R8 tx byte"), tx_byte_o, e_tx);
        if (cv) begin
            chk(cfg_ok_o == fit, pick(t, "R9 ok"), cfg_ok_o, fit);
            chk(cfg_err_o == !fit, pick(t, "R9 err"), cfg_err_o, !fit);
        end
        chk(hit_o == e_hit, pick(t, "R10 hit"), hit_o, e_hit);
        if (e_hit) begin
            chk(hit_addr_o == e_ha, pick(t, "R10 addr"), hit_addr_o, e_ha);
            chk(hit_data_o == rb, pick(t, "R10 data"), hit_data_o, rb);
        end
        start_i = 0; stop_i = 0; rx_vld_i = 0; tx_req_i = 0; cfg_vld_i = 0;
    endtask

    task automatic st(bit [6:0] a, bit rd, string t); step(1, a, rd, 0, 0, 0, 0, 0, 0, 0, t); endtask
    task automatic sp(string t); step(0, 0, 0, 1, 0, 0, 0, 0, 0, 0, t); endtask
    task automatic wr(bit [7:0] b, string t); step(0, 0, 0, 0, 1, b, 0, 0, 0, 0, t); endtask
    task automatic rdb(string t); step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, t); endtask
    task automatic cfg(bit [7:0] s, bit [8:0] z, string t); step(0, 0, 0, 0, 0, 0, 0, 1, s, z, t); endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1; fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED);
        for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'h00;
        m_ptr = 0; m_sel = 0; m_pn = 0; m_wv = 0; m_lo = 0; m_hi = 0;
        rst_n = 0; en_i = 1; start_i = 0; start_addr_i = 0; start_rd_i = 0; stop_i = 0;
        rx_vld_i = 0; rx_byte_i = 0; tx_req_i = 0; cfg_vld_i = 0; cfg_start_i = 0; cfg_size_i = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk({rx_ack_vld_o, rx_ack_o, tx_vld_o, cfg_ok_o, cfg_err_o, hit_o} == 6'b0, "R1 flags", 0, 0);
        chk(tx_byte_o == 8'h00, "R1 tx byte", tx_byte_o, 0);
        st(7'h01, 1, "");
        rdb("R1 first read");
        // R3 / R6 pointer load and wrap
        st(7'h01, 0, "");
        wr(8'hFE, "R3 load ack");
        wr(8'hAA, "R6"); wr(8'hBB, "R6"); wr(8'hCC, "R6 wrap");
        st(7'h01, 0, "");
        wr(8'hFE, "R3 reload");
        st(7'h01, 1, "");
        rdb("R5 read FE"); rdb("R5 read FF"); rdb("R6 read after wrap");
        // R4 read start disarms load
        st(7'h01, 0, ""); st(7'h01, 1, "");
        wr(8'h55, "R4 data after read start");
        st(7'h01, 0, ""); wr(8'h01, "R4"); st(7'h01, 1, ""); rdb("R4 readback");
        // R2 other address ignored
        st(7'h05, 0, "");
        wr(8'h11, "R2 nak"); rdb("R2 zero");
        st(7'h01, 0, ""); sp(""); wr(8'h22, "R2 after stop");
        // R8 disabled
        en_i = 0;
        st(7'h01, 0, "");
        wr(8'h33, "R8 nak"); rdb("R8 zero");
        en_i = 1;
        wr(8'h00, "R8 pointer load survives"); st(7'h01, 1, ""); rdb("R8 mem intact");
        // R9 window requests
        cfg(8'h10, 9'd0, "R9 zero size");
        cfg(8'd200, 9'd57, "R9 past end");
        cfg(8'd200, 9'd56, "R9 to end");
        cfg(8'h20, 9'd4, "R9 small");
        cfg(8'h80, 9'd300, "R9 oversize");
        // R10 window edges
        st(7'h01, 0, ""); wr(8'h1E, "R10 load no hit");
        for (int i = 0; i < 7; i++) wr(8'h40 + 8'(i), "R10 edge");
        // R11 write and window update in same cycle
        st(7'h01, 0, ""); wr(8'h30, "R11 load");
        step(0, 0, 0, 0, 1, 8'h77, 0, 1, 8'h30, 9'd1, "R11 old window");
        st(7'h01, 0, ""); wr(8'h30, "R11 load");
        wr(8'h78, "R11 new window");
        // random traffic
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = $urandom % 100;
            if (r < 8)
                st(($urandom % 5 == 0) ? 7'($urandom) : 7'h01, 1'($urandom), "");
            else if (r < 12) sp("");
            else if (r < 50) wr(8'($urandom), "");
            else if (r < 80) rdb("");
            else if (r < 89) begin
                bit [8:0] z;
                z = ($urandom % 4 == 0) ? 9'($urandom % 300) : 9'($urandom % 40);
                step(0, 0, 0, 0, (r >= 86), 8'($urandom), 0, 1, 8'($urandom), z,
                     (r >= 86) ? "" : "");
            end else if (r < 91) en_i = ($urandom % 10 != 0);
            else step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
        end
        en_i = 1;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule